// File: doc/BRIEF.md
# Exception Status and Cause Controller

This block is the trap-handling part of a processor's system control unit. It holds four registers: a status word, a cause word, the saved exception PC and the last faulting data address. Each cycle it looks at a synchronous exception request from the pipeline and at five external interrupt lines. From these it decides whether the pipeline must trap. When a trap is accepted it asserts a redirect to a fixed handler address in the same cycle. On the following clock edge it records why the trap happened and where it happened.

The status word carries a three-deep stack of mode and enable pairs. Accepting a trap pushes this stack, so the processor enters kernel mode with interrupts disabled. A return command pops it. The pipeline reads and writes the registers by register number, as move-to and move-from operations do. Reads are combinational.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, all four registers read as zero and `redirect` is low.
- R2: When `exc_req` is high, `redirect` is high in that same cycle and `target` equals 0x80000080. After the next clock edge, register 14 holds `exc_pc`, and bits 5:2 of register 13 hold `exc_code`.
- R3: Status bits 5:0 form three pairs, stored from the low end as current, previous and old. In each pair the low bit is the interrupt enable (1 = enabled) and the high bit is the mode (1 = user). An accepted trap shifts bits 5:0 left by two and clears the new current pair.
- R4: A return (`eret`) in a cycle with no trap copies the previous pair into the current pair and the old pair into the previous pair. The old pair keeps its value.
- R5: Bits 12:8 of register 13 show the interrupt lines as they were sampled at the previous clock edge. Line n appears at bit 8+n.
- R6: An interrupt trap is taken only when some sampled line has its mask bit set and the current enable bit (status bit 0) is 1. The mask bit for line n is status bit 8+n. An interrupt trap records code 0.
- R7: A synchronous request and an interrupt in the same cycle cause a single trap. That trap records the synchronous request's code, and the interrupt's pending bit stays visible in the cause register.
- R8: Register 8 is loaded with `exc_addr` only on an accepted synchronous request with code 4 or 5. All other traps leave it unchanged.
- R9: Reads of registers 8, 12, 13 and 14 return the values above, and any other register number reads zero. Writes to register 12 set only bits 12:8 and 5:0, and its other bits read zero. Register 14 is fully writable. Writes to registers 8 and 13 are ignored.
- R10: In a single cycle a trap has priority over a return, and a return has priority over a write to register 12. A write that loses is dropped completely. A write to register 14 in a trap cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception request from the pipeline |
| exc_code | input | 4 | Cause code of the request |
| exc_pc | input | 32 | PC of the instruction being trapped or interrupted |
| exc_addr | input | 32 | Faulting data address for address errors |
| irq | input | 5 | External interrupt lines |
| eret | input | 1 | Return from exception command |
| reg_num | input | 5 | Register number for read and write |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| redirect | output | 1 | Trap accepted this cycle |
| target | output | 32 | Handler address while `redirect` is high, zero otherwise |

## Verification
A synchronous request and an interrupt can both be ready in the same cycle. The same cycle can also carry a return or a register write. The bench leaves an unmasked interrupt line high with interrupts enabled, and asserts a request with code 10 exactly in the cycle the interrupt would fire. It then reads the cause register to confirm that it holds code 10 with the pending bit still set. A further cycle combines a trap, a return and a status write, and the status read that follows is compared against a behavioural model that applies only the trap's push.

// File: rtl/trap_ctrl.sv
module trap_ctrl #(
  parameter int          NIRQ    = 5,
  parameter logic [31:0] HANDLER = 32'h8000_0080
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_req,
  input  logic [3:0]      exc_code,
  input  logic [31:0]     exc_pc,
  input  logic [31:0]     exc_addr,
  input  logic [NIRQ-1:0] irq,
  input  logic            eret,
  input  logic [4:0]      reg_num,
  input  logic            reg_wr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            redirect,
  output logic [31:0]     target
);
  localparam logic [4:0] N_BAD = 5'd8;
  localparam logic [4:0] N_ST  = 5'd12;
  localparam logic [4:0] N_CS  = 5'd13;
  localparam logic [4:0] N_EPC = 5'd14;
  localparam int         IPLO  = 8;

  logic [5:0]      stk;
  logic [NIRQ-1:0] imask, ip;
  logic [3:0]      code;
  logic [31:0]     epc, bad;
  logic [31:0]     st_v, cs_v;

  wire int_go   = (|(ip & imask)) & stk[0];
  wire addr_err = exc_req && (exc_code == 4'd4 || exc_code == 4'd5);
  wire wr_st    = reg_wr && (reg_num == N_ST);
  wire wr_epc   = reg_wr && (reg_num == N_EPC) && !redirect;

  assign redirect = exc_req | int_go;
  assign target   = redirect ? HANDLER : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stk   <= '0;
      imask <= '0;
      ip    <= '0;
      code  <= '0;
      epc   <= '0;
      bad   <= '0;
    end else begin
      ip <= irq;
      if (redirect) begin
        stk  <= {stk[3:0], 2'b00};
        code <= exc_req ? exc_code : 4'd0;
        epc  <= exc_pc;
        if (addr_err) bad <= exc_addr;
      end else if (eret) begin
        stk <= {stk[5:4], stk[5:2]};
      end else if (wr_st) begin
        stk   <= reg_wdata[5:0];
        imask <= reg_wdata[IPLO +: NIRQ];
      end
      if (wr_epc) epc <= reg_wdata;
    end
  end

  always_comb begin
    st_v = '0;
    st_v[5:0] = stk;
    st_v[IPLO +: NIRQ] = imask;
    cs_v = '0;
    cs_v[5:2] = code;
    cs_v[IPLO +: NIRQ] = ip;
    case (reg_num)
      N_BAD:   reg_rdata = bad;
      N_ST:    reg_rdata = st_v;
      N_CS:    reg_rdata = cs_v;
      N_EPC:   reg_rdata = epc;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
  parameter int          NIRQ    = 5,
  parameter logic [31:0] HANDLER = 32'h8000_0080
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_req,
  input logic [3:0]      exc_code,
  input logic [31:0]     exc_pc,
  input logic            eret,
  input logic            redirect,
  input logic [31:0]     target,
  input logic [5:0]      stk,
  input logic [3:0]      code,
  input logic [31:0]     epc,
  input logic [31:0]     bad,
  input logic [NIRQ-1:0] ip,
  input logic [NIRQ-1:0] imask
);
  p_vector_r2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> target == HANDLER);
  p_epc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> epc == $past(exc_pc));
  p_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> stk == {$past(stk[3:0]), 2'b00});
  p_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !redirect) |=> stk == {$past(stk[5:4]), $past(stk[5:2])});
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !exc_req) |-> (stk[0] && (|(ip & imask))));
  p_sync_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> code == $past(exc_code));
  p_bad_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_req && (exc_code == 4'd4 || exc_code == 4'd5)) |=> $stable(bad));
endmodule

bind trap_ctrl trap_ctrl_chk #(.NIRQ(NIRQ), .HANDLER(HANDLER)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
  .exc_pc(exc_pc), .eret(eret), .redirect(redirect), .target(target),
  .stk(stk), .code(code), .epc(epc), .bad(bad), .ip(ip), .imask(imask)
);

// File: tb/trap_ctrl_bench.sv
module trap_ctrl_bench;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        exc_req = 0;
  logic [3:0]  exc_code = 0;
  logic [31:0] exc_pc = 0, exc_addr = 0;
  logic [4:0]  irq = 0;
  logic        eret = 0;
  logic [4:0]  reg_num = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata, target;
  logic        redirect;

  int total = 0, fails = 0;
  bit done = 0;

  logic [5:0]  m_stk = 0;
  logic [4:0]  m_mask = 0, m_ip = 0;
  logic [3:0]  m_code = 0;
  logic [31:0] m_epc = 0, m_bad = 0;

  trap_ctrl u_trap_ctrl (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
    .exc_pc(exc_pc), .exc_addr(exc_addr), .irq(irq), .eret(eret),
    .reg_num(reg_num), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .redirect(redirect), .target(target)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic m_go();
    return exc_req | ((|(m_ip & m_mask)) & m_stk[0]);
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] n);
    case (n)
      5'd8:    return m_bad;
      5'd12:   return {19'd0, m_mask, 2'b00, m_stk};
      5'd13:   return {19'd0, m_ip, 2'b00, m_code, 2'b00};
      5'd14:   return m_epc;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tg, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tg, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  task automatic tick(input string tg);
    logic go;
    @(negedge clk);
    go = m_go();
    chk(tg, "redirect", {31'd0, redirect}, {31'd0, go});
    chk(tg, "target", target, go ? 32'h8000_0080 : 32'd0);
    chk(tg, "rdata", reg_rdata, m_read(reg_num));
    @(posedge clk);
    if (go) begin
      m_stk  = {m_stk[3:0], 2'b00};
      m_code = exc_req ? exc_code : 4'd0;
      m_epc  = exc_pc;
      if (exc_req && (exc_code == 4'd4 || exc_code == 4'd5)) m_bad = exc_addr;
    end else if (eret) begin
      m_stk = {m_stk[5:4], m_stk[5:2]};
    end else if (reg_wr && reg_num == 5'd12) begin
      m_stk  = reg_wdata[5:0];
      m_mask = reg_wdata[12:8];
    end
    if (!go && reg_wr && reg_num == 5'd14) m_epc = reg_wdata;
    m_ip = irq;
    #1;
    exc_req = 0; eret = 0; reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] n, input string tg);
    reg_num = n;
    tick(tg);
  endtask

  task automatic wr(input logic [4:0] n, input logic [31:0] d, input string tg);
    reg_num = n; reg_wr = 1; reg_wdata = d;
    tick(tg);
  endtask

  task automatic trap(input logic [3:0] c, input logic [31:0] pc, input logic [31:0] a, input string tg);
    exc_req = 1; exc_code = c; exc_pc = pc; exc_addr = a; reg_num = 5'd12;
    tick(tg);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(5'd8, "R1"); rd(5'd12, "R1"); rd(5'd13, "R1"); rd(5'd14, "R1");
    rd(5'd3, "R9");
    wr(5'd12, 32'hFFFF_FFFF, "R9"); rd(5'd12, "R9");
    wr(5'd12, 32'h0000_000D, "R9"); rd(5'd12, "R9");
    wr(5'd13, 32'hFFFF_FFFF, "R9"); rd(5'd13, "R9");
    wr(5'd8, 32'h1234_5678, "R9"); rd(5'd8, "R9");
    wr(5'd14, 32'hCAFE_0004, "R9"); rd(5'd14, "R9");
    trap(4'd8, 32'h0040_0010, 32'h0, "R2");
    rd(5'd14, "R2"); rd(5'd13, "R2"); rd(5'd12, "R3"); rd(5'd8, "R8");
    trap(4'd4, 32'h0040_0020, 32'h1000_0003, "R8"); rd(5'd8, "R8");
    trap(4'd5, 32'h0040_0024, 32'h1000_0101, "R8"); rd(5'd8, "R8");
    trap(4'd12, 32'h0040_0028, 32'h0000_DEAD, "R8"); rd(5'd8, "R8");
    rd(5'd12, "R3");
    wr(5'd12, 32'h0000_002D, "R4");
    for (int i = 0; i < 3; i++) begin eret = 1; rd(5'd12, "R4"); end
    rd(5'd12, "R4");
    wr(5'd12, 32'h0000_0401, "R6");
    irq = 5'b01000;
    rd(5'd13, "R5"); rd(5'd13, "R5"); rd(5'd12, "R6");
    irq = 5'b00100;
    rd(5'd13, "R6"); rd(5'd13, "R6"); rd(5'd13, "R6"); rd(5'd12, "R6");
    eret = 1; rd(5'd12, "R6");
    exc_pc = 32'h0040_0100; rd(5'd14, "R6"); rd(5'd14, "R6");
    irq = 5'b00000;
    rd(5'd13, "R5"); rd(5'd13, "R5");
    wr(5'd12, 32'h0000_0400, "R6");
    irq = 5'b00100;
    rd(5'd13, "R6"); rd(5'd13, "R6"); rd(5'd12, "R6");
    wr(5'd12, 32'h0000_0401, "R7");
    exc_req = 1; exc_code = 4'd10; exc_pc = 32'h0040_0200; reg_num = 5'd13;
    tick("R7");
    rd(5'd13, "R7"); rd(5'd14, "R7"); rd(5'd12, "R7");
    irq = 5'b00000;
    rd(5'd13, "R5");
    wr(5'd12, 32'h0000_0005, "R10");
    exc_req = 1; exc_code = 4'd9; exc_pc = 32'h0040_0300; eret = 1;
    reg_num = 5'd12; reg_wr = 1; reg_wdata = 32'h0000_003F;
    tick("R10");
    rd(5'd12, "R10");
    eret = 1; reg_num = 5'd12; reg_wr = 1; reg_wdata = 32'h0000_1F3F;
    tick("R10");
    rd(5'd12, "R10");
    exc_req = 1; exc_code = 4'd8; exc_pc = 32'h0040_0400;
    reg_num = 5'd14; reg_wr = 1; reg_wdata = 32'h1111_1111;
    tick("R10");
    rd(5'd14, "R10");
    summary();
  end
endmodule